// File: doc/BRIEF.md
# Keyed-Service System Watchdog

This block is a memory-mapped system watchdog. Software programs a 16-bit reload count, an enable, an expiry-action select and a prescale select through one control register. A down-counter then counts toward zero, either on every system clock or once per prescaler period. If software does not service it in time, the block raises a reset request or an interrupt request.

Servicing is deliberately awkward, so that a runaway program cannot keep the watchdog alive by chance. Two fixed 16-bit values must be written to the service register, in a fixed order. The enable can be set or cleared only by the first control write after reset. After that it is frozen until the next reset. The live count can be read back at any time. The system reset generator and the interrupt controller that consume the two request outputs sit outside this block.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, the control word at byte address 0x04 reads 0xFFFF0000: reload 0xFFFF and enable, action and prescale all 0. The count at 0x08 reads 0x0000FFFF. Address 0x00 reads 0. Both request outputs are low.
- R2: A write to 0x04 updates only the byte lanes whose enables are set. The fields are reload in bits 31:16, enable in bit 2, action select in bit 1 and prescale select in bit 0. The write loads the counter from the resulting reload value and clears the prescaler. The control fields change on no other write.
- R3: Only the first write to 0x04 after reset, and only when its byte lane 0 is enabled, can change the enable bit. Every later write leaves it as it is, whether that write tries to enable a disabled watchdog or to disable an enabled one.
- R4: While the watchdog is enabled with prescale off, the counter drops by one on every clock. It never rises except on a reload.
- R5: While the watchdog is enabled with prescale on, the counter drops by one once every 2**PRESC_LOG2 clocks. The default is 65536 clocks.
- R6: A write of 0x556C followed by the next service write of 0xAA39 reloads the counter from the reload field. Each service write goes to byte address 0x0E with data in bits 31:16 and byte lanes 3 and 2 both enabled. The completed pair also clears a pending interrupt request and the prescaler. Other bus cycles may come between the two writes.
- R7: Any service write that is not the next expected key returns the checker to waiting for 0x556C, and the counter is not reloaded. This covers a wrong value, 0xAA39 without a preceding 0x556C, a repeated 0x556C, and a write missing lane 2 or lane 3.
- R8: With action select 1, the decrement that takes the counter to zero raises reset_req for exactly one clock. The counter then stays at zero.
- R9: With action select 0, the same event raises irq_req. It stays high until a valid service pair completes.
- R10: While the watchdog is disabled, the counter holds its value and both request outputs stay low.
- R11: The count register is read-only. A write to 0x08 changes neither the count nor any control field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 4 | Byte-lane enables of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| reset_req | output | 1 | One-cycle reset request on expiry |
| irq_req | output | 1 | Level interrupt request on expiry |

## Verification
The bench goes after four kinds of corner case.

The first is the key order: a lone second key, a doubled first key, a wrong value between the keys, and a half-width service write. A checker that resynchronises wrongly would reload on one of these, and the count readback would jump up.

The second is the enable lock. It is tried in both directions in separate reset epochs. A missing lock would let the counter stop, or start, where it should not.

The third is the expiry edge. A counter that wraps instead of holding, a reset pulse wider than one clock, or an interrupt that drops by itself would show up at once on the outputs.

The last is a byte-lane control write and the prescaled rate. A wrong lane merge or a wrong prescale period shifts the expiry cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int TC_W = 16;

    // byte addresses inside the 0x100 window
    localparam logic [7:0] A_RSVD  = 8'h00;
    localparam logic [7:0] A_CTRL  = 8'h04;
    localparam logic [7:0] A_COUNT = 8'h08;
    localparam logic [7:0] A_SVC   = 8'h0E;

    localparam logic [15:0] KEY_ARM   = 16'h556C;
    localparam logic [15:0] KEY_FIRE  = 16'hAA39;
    localparam logic [15:0] TC_RESET  = 16'hFFFF;

    typedef struct packed {
        logic [TC_W-1:0] reload;
        logic            en;
        logic            act_reset;
        logic            pre_on;
    } ctrl_t;

    typedef enum logic {
        SEQ_WAIT_ARM  = 1'b0,
        SEQ_WAIT_FIRE = 1'b1
    } seq_t;

    typedef struct packed {
        logic        hit_ctrl;
        logic        hit_svc;
        logic        svc_both;
        logic [15:0] svc_val;
    } bus_ev_t;

    function automatic logic [31:0] ctrl_image(ctrl_t c);
        return {c.reload, 13'd0, c.en, c.act_reset, c.pre_on};
    endfunction

    function automatic logic [31:0] lane_merge(logic [31:0] old_w,
                                               logic [31:0] new_w,
                                               logic [3:0]  be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin
            r[8*i +: 8] = be[i] ? new_w[8*i +: 8] : old_w[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    input  logic [TC_W-1:0]   cnt,
    output ctrl_t             ctrl,
    output ctrl_t             ctrl_nx,
    output bus_ev_t           ev,
    output logic [31:0]       rdata
);

    logic        locked;
    logic [31:0] merged;

    always_comb begin
        ev.hit_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
        ev.hit_svc  = bus_wr && (bus_addr == ADDR_W'(A_SVC));
        ev.svc_both = &bus_be[3:2];
        ev.svc_val  = bus_wdata[31:16];
    end

    assign merged = lane_merge(ctrl_image(ctrl), bus_wdata, bus_be);

    always_comb begin
        ctrl_nx           = ctrl;
        ctrl_nx.reload    = merged[31:16];
        ctrl_nx.act_reset = merged[1];
        ctrl_nx.pre_on    = merged[0];
        if (!locked && bus_be[0]) begin
            ctrl_nx.en = merged[2];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.reload    <= TC_RESET;
            ctrl.en        <= 1'b0;
            ctrl.act_reset <= 1'b0;
            ctrl.pre_on    <= 1'b0;
            locked         <= 1'b0;
        end else if (ev.hit_ctrl) begin
            ctrl   <= ctrl_nx;
            locked <= 1'b1;
        end
    end

    always_comb begin
        if (bus_addr == ADDR_W'(A_CTRL)) begin
            rdata = ctrl_image(ctrl);
        end else if (bus_addr == ADDR_W'(A_COUNT)) begin
            rdata = {{(32-TC_W){1'b0}}, cnt};
        end else begin
            rdata = 32'd0;
        end
    end

    // R3: once the first control write has happened, enable never moves
    assert_en_locked_R3: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(ctrl.en));

    // R2, R11: control fields only change on a control write
    assert_ctrl_only_by_write_R2: assert property (@(posedge clk) disable iff (rst)
        !ev.hit_ctrl |=> $stable(ctrl));

endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
    parameter int PRE_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic pre_on,
    input  logic restart,
    output logic tick
);

    logic [PRE_W-1:0] ps;

    assign tick = run && (!pre_on || (&ps));

    always_ff @(posedge clk) begin
        if (rst || restart || !pre_on) begin
            ps <= '0;
        end else if (run) begin
            ps <= ps + 1'b1;
        end
    end

    // R5: prescaled ticks are never back to back
    assert_tick_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && pre_on && !restart) |=> !tick);

endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hit_svc,
    input  logic        svc_both,
    input  logic [15:0] svc_val,
    output logic        svc_ok
);

    seq_t state_q;
    logic is_arm;
    logic is_fire;

    assign is_arm  = hit_svc && svc_both && (svc_val == KEY_ARM);
    assign is_fire = hit_svc && svc_both && (svc_val == KEY_FIRE);
    assign svc_ok  = (state_q == SEQ_WAIT_FIRE) && is_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_WAIT_ARM;
        end else if (hit_svc) begin
            state_q <= (state_q == SEQ_WAIT_ARM && is_arm) ? SEQ_WAIT_FIRE
                                                            : SEQ_WAIT_ARM;
        end
    end

    // R7: any service write while armed ends the attempt
    assert_disarm_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_WAIT_FIRE && hit_svc) |=> (state_q == SEQ_WAIT_ARM));

    // R6: a full-width first key from idle arms the checker
    assert_arm_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_WAIT_ARM && is_arm) |=> (state_q == SEQ_WAIT_FIRE));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [TC_W-1:0] reload,
    input  logic            act_reset,
    input  logic            en,
    input  logic            ctrl_wr,
    input  logic [TC_W-1:0] nx_reload,
    input  logic            nx_en,
    input  logic            svc_ok,
    input  logic            tick,
    output logic [TC_W-1:0] cnt,
    output logic            reset_req,
    output logic            irq_req
);

    logic last_step;

    assign last_step = tick && (cnt == TC_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= TC_RESET;
            reset_req <= 1'b0;
            irq_req   <= 1'b0;
        end else begin
            reset_req <= 1'b0;
            if (ctrl_wr) begin
                cnt <= nx_reload;
                if (!nx_en) begin
                    irq_req <= 1'b0;
                end
            end else if (svc_ok) begin
                cnt     <= reload;
                irq_req <= 1'b0;
            end else if (tick && cnt != '0) begin
                cnt <= cnt - 1'b1;
                if (last_step) begin
                    if (act_reset) begin
                        reset_req <= 1'b1;
                    end else begin
                        irq_req <= 1'b1;
                    end
                end
            end
        end
    end

    // R8: reset request lasts one clock
    assert_pulse_one_R8: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    // R8: reset request only with a zero count in reset-action mode
    assert_pulse_at_zero_R8: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> (cnt == '0 && act_reset));

    // R10: a disabled watchdog requests nothing
    assert_quiet_off_R10: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!reset_req && !irq_req));

    // R4: counter never climbs without a reload
    assert_no_climb_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_wr && !svc_ok) |=> (cnt <= $past(cnt)));

    // R9: interrupt level holds until serviced
    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !svc_ok && !ctrl_wr) |=> irq_req);

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdog_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PRESC_LOG2 = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              reset_req,
    output logic              irq_req
);

    ctrl_t           ctrl;
    ctrl_t           ctrl_nx;
    bus_ev_t         ev;
    logic [TC_W-1:0] cnt;
    logic            svc_ok;
    logic            tick;

    wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .cnt       (cnt),
        .ctrl      (ctrl),
        .ctrl_nx   (ctrl_nx),
        .ev        (ev),
        .rdata     (bus_rdata)
    );

    wdog_key_seq u_keys (
        .clk      (clk),
        .rst      (rst),
        .hit_svc  (ev.hit_svc),
        .svc_both (ev.svc_both),
        .svc_val  (ev.svc_val),
        .svc_ok   (svc_ok)
    );

    wdog_tick #(.PRE_W(PRESC_LOG2)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.en),
        .pre_on  (ctrl.pre_on),
        .restart (ev.hit_ctrl || svc_ok),
        .tick    (tick)
    );

    wdog_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .reload    (ctrl.reload),
        .act_reset (ctrl.act_reset),
        .en        (ctrl.en),
        .ctrl_wr   (ev.hit_ctrl),
        .nx_reload (ctrl_nx.reload),
        .nx_en     (ctrl_nx.en),
        .svc_ok    (svc_ok),
        .tick      (tick),
        .cnt       (cnt),
        .reset_req (reset_req),
        .irq_req   (irq_req)
    );

endmodule

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;

    localparam int CLK_NS = 10;
    localparam int PW     = 4;
    localparam int PDIV   = 1 << PW;

    logic        clk   = 1'b0;
    logic        rst   = 1'b1;
    logic [7:0]  addr  = 8'h00;
    logic        wr    = 1'b0;
    logic [3:0]  be    = 4'h0;
    logic [31:0] wdata = 32'd0;
    wire  [31:0] rdata;
    wire         reset_req;
    wire         irq_req;

    always #(CLK_NS/2) clk = ~clk;

    wdog_keyed #(.ADDR_W(8), .PRESC_LOG2(PW)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_be    (be),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .reset_req (reset_req),
        .irq_req   (irq_req)
    );

    // behavioural reference
    int m_tc = 16'hFFFF, m_en = 0, m_sel = 0, m_pre = 0, m_lock = 0;
    int m_cnt = 16'hFFFF, m_ps = 0, m_arm = 0, m_rr = 0, m_irq = 0;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 0;
    string cur = "R1";

    always @(posedge clk) begin : model
        logic [31:0] old_w, new_w;
        bit tick, ok, full;
        if (rst) begin
            m_tc = 16'hFFFF; m_en = 0; m_sel = 0; m_pre = 0; m_lock = 0;
            m_cnt = 16'hFFFF; m_ps = 0; m_arm = 0; m_rr = 0; m_irq = 0;
        end else begin
            m_rr = 0;
            ok   = 0;
            if (wr && addr == 8'h0E) begin
                full = (be[3] && be[2]);
                ok = (m_arm == 1) && full && (wdata[31:16] == 16'hAA39);
                m_arm = (m_arm == 0 && full && wdata[31:16] == 16'h556C) ? 1 : 0;
            end
            tick = (m_en != 0) && ((m_pre == 0) || (m_ps == PDIV - 1));
            if (wr && addr == 8'h04) begin
                old_w = {m_tc[15:0], 13'd0, m_en[0], m_sel[0], m_pre[0]};
                new_w = old_w;
                for (int i = 0; i < 4; i++)
                    if (be[i]) new_w[8*i +: 8] = wdata[8*i +: 8];
                m_tc  = new_w[31:16];
                m_sel = new_w[1];
                m_pre = new_w[0];
                if (m_lock == 0 && be[0]) m_en = new_w[2];
                m_lock = 1;
                m_cnt  = m_tc;
                m_ps   = 0;
                if (m_en == 0) m_irq = 0;
            end else if (ok) begin
                m_cnt = m_tc;
                m_ps  = 0;
                m_irq = 0;
            end else begin
                if (m_en != 0 && m_pre != 0) m_ps = (m_ps + 1) % PDIV;
                if (tick && m_cnt > 0) begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) begin
                        if (m_sel != 0) m_rr = 1; else m_irq = 1;
                    end
                end
            end
            if (m_pre == 0) m_ps = 0;
        end
    end

    task automatic compare();
        logic [31:0] exp_rd;
        if (addr == 8'h04)      exp_rd = {m_tc[15:0], 13'd0, m_en[0], m_sel[0], m_pre[0]};
        else if (addr == 8'h08) exp_rd = {16'd0, m_cnt[15:0]};
        else                    exp_rd = 32'd0;
        vectors++;
        if (rdata !== exp_rd || reset_req !== m_rr[0] || irq_req !== m_irq[0]) begin
            miscompares++;
            $display("FAIL %s: addr=%h rdata=%h exp=%h reset_req=%b exp=%b irq_req=%b exp=%b",
                     cur, addr, rdata, exp_rd, reset_req, m_rr[0], irq_req, m_irq[0]);
        end
    endtask

    task automatic step(input logic r, input logic [7:0] a, input logic w,
                        input logic [3:0] b, input logic [31:0] d);
        @(negedge clk);
        compare();
        rst = r; addr = a; wr = w; be = b; wdata = d;
    endtask

    task automatic idle(input int n, input logic [7:0] a);
        for (int i = 0; i < n; i++) step(1'b0, a, 1'b0, 4'h0, 32'd0);
    endtask

    task automatic wr_ctrl(input logic [31:0] d, input logic [3:0] b);
        step(1'b0, 8'h04, 1'b1, b, d);
    endtask

    task automatic svc(input logic [15:0] v, input logic [3:0] b);
        step(1'b0, 8'h0E, 1'b1, b, {v, 16'h0000});
    endtask

    initial begin
        repeat (3) step(1'b1, 8'h00, 1'b0, 4'h0, 32'd0);
        // R1: reset readback
        cur = "R1";
        idle(2, 8'h00); idle(2, 8'h04); idle(2, 8'h08);
        // R11: write to count is ignored
        cur = "R11";
        step(1'b0, 8'h08, 1'b1, 4'hF, 32'h0000_1234);
        idle(3, 8'h08); idle(2, 8'h04);
        // R10: disabled, counter holds
        cur = "R10";
        idle(10, 8'h08);
        // R2/R4/R8: enable, reset action, no prescale, reload 0x10
        cur = "R2";
        wr_ctrl(32'h0010_0006, 4'hF);
        idle(2, 8'h04);
        cur = "R4";
        idle(8, 8'h08);
        cur = "R8";
        idle(14, 8'h08);
        // R3: try to disable; enable stays, interrupt action now
        cur = "R3";
        wr_ctrl(32'h0020_0000, 4'hF);
        idle(3, 8'h04);
        cur = "R9";
        idle(45, 8'h08);
        // R7: broken sequences do not reload
        cur = "R7";
        svc(16'hAA39, 4'hC); idle(2, 8'h08);
        svc(16'h556C, 4'hC); svc(16'h1234, 4'hC); svc(16'hAA39, 4'hC); idle(2, 8'h08);
        svc(16'h556C, 4'hC); svc(16'h556C, 4'hC); svc(16'hAA39, 4'hC); idle(2, 8'h08);
        svc(16'h556C, 4'h4); svc(16'hAA39, 4'hC); idle(2, 8'h08);
        svc(16'h556C, 4'hC); svc(16'hAA39, 4'h8); idle(2, 8'h08);
        // R6: valid pair, with other traffic in between
        cur = "R6";
        svc(16'h556C, 4'hC); idle(2, 8'h04); svc(16'hAA39, 4'hC);
        idle(8, 8'h08);
        // R5: prescaled rate, reload 3
        cur = "R5";
        wr_ctrl(32'h0003_0001, 4'hF);
        idle(40, 8'h08);
        svc(16'h556C, 4'hC); svc(16'hAA39, 4'hC);
        idle(60, 8'h08);
        // R2: single-lane control write
        cur = "R2";
        wr_ctrl(32'h0100_0000, 4'h8);
        idle(3, 8'h04); idle(3, 8'h08);
        // R3/R10: new epoch, first write disables, later enable refused
        cur = "R3";
        repeat (2) step(1'b1, 8'h00, 1'b0, 4'h0, 32'd0);
        wr_ctrl(32'h0008_0000, 4'hF);
        wr_ctrl(32'h0008_0004, 4'hF);
        idle(3, 8'h04);
        cur = "R10";
        idle(20, 8'h08);
        idle(1, 8'h00);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule